// File: doc/BRIEF.md
# Dual-Clock Latched Shift Register with Open-Drain Sink Outputs

This block is a serial-in register that feeds a parallel output stage. Bits arrive on a serial input and move one stage deeper on each rising edge of a shift clock. A second, independent storage clock copies all stages at once into a storage bank. The storage bank drives a row of open-drain sink switches. Each switch either pulls its pin low or leaves it floating. An active-low output enable can switch every sink off together without disturbing any register.

Several copies can be chained. The cascade output of one copy feeds the serial input of the next. The cascade output is taken from an extra flip-flop that samples the deepest stage on the falling shift-clock edge. The next device in the chain samples on the rising edge, so this gives it half a clock period of hold margin. An active-low reset clears the shift stages, the storage bank and the cascade flip-flop at once, with no clock needed.

The outputs are control signals for a power switch. Drive strength, clamping and thermal limits are left to the pad.

Top module: `shreg_latched_driver`

## Requirements
- R1: On each rising edge of `shift_clk`, stage 0 takes `ser_in` and stage i (for i of 1 and above) takes the previous value of stage i-1. The stages are numbered 0 to STAGES-1.
- R2: On each rising edge of `latch_clk`, the storage bank loads every shift stage in parallel. Shifting alone never changes `sink_en`.
- R3: While `rst_n` is low, the shift stages, the storage bank and the cascade flip-flop are all 0, starting immediately and without any clock edge. As a result, `sink_en` reads all zeros and `cascade_out` reads 0.
- R4: `cascade_out` takes the value of stage STAGES-1 on each falling edge of `shift_clk`. During the high phase that follows a rising edge, it still shows the value the stage had before that edge.
- R5: While `out_en_n` is 0, bit i of `sink_en` equals storage bit i, where 1 means the pin sinks current (pulled low) and 0 means the pin floats. Every bit of `drive_valid` is 1 in this state.
- R6: While `out_en_n` is 1, every bit of `sink_en` and of `drive_valid` is 0. Toggling `out_en_n` leaves the shift stages and the storage bank unchanged.
- R7: When `shift_clk` and `latch_clk` rise together, the storage bank captures the stage values from before that shift. The storage bank therefore lags the shift register by one shift.
- R8: Take two devices where `cascade_out` of the first drives `ser_in` of the second, with shared clocks. After 16 shifts of a word sent MSB first, one `latch_clk` pulse places bits 15..8 in the second device's `sink_en` and bits 7..0 in the first device's `sink_en`, MSB at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; stages advance on its rising edge, cascade flop updates on its falling edge |
| latch_clk | input | 1 | Storage clock; rising edge copies the stages into the storage bank |
| rst_n | input | 1 | Asynchronous active-low clear of every register |
| ser_in | input | 1 | Serial data into stage 0 |
| out_en_n | input | 1 | Active-low enable of the sink outputs |
| sink_en | output | STAGES | Per-pin pull-down command (1 = sink, 0 = float) |
| drive_valid | output | STAGES | Per-pin flag: output stage active (not forced off) |
| cascade_out | output | 1 | Retimed copy of the last stage for chaining |

## Verification
A shift result is due at the rising `shift_clk` edge. The same edge also updates the second device's first stage from the first device's cascade. A storage result shows on `sink_en` as soon as the rising `latch_clk` edge has passed, because the output gate is combinational after the storage bank. `cascade_out` moves only at the falling edge, half a period after the shift. Reset and output-enable effects are due at once, with no edge.

The bench changes inputs only while both clocks are low. It samples the register results a few nanoseconds after the edge concerned. It probes `cascade_out` once inside the high phase and once after the falling edge, so the half-cycle retiming is checked on both sides. Reset and enable effects are sampled 2 ns after the level change, before any clock.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam int unsigned STAGES_DEF = 8;

  // Per-pin output decode: {drive_valid, sink}
  function automatic logic [1:0] pin_gate(input logic stored, input logic en_n);
    logic active;
    active   = ~en_n;
    pin_gate = {active, active & stored};
  endfunction
endpackage

// File: rtl/shreg_shift_chain.sv
module shreg_shift_chain #(
  parameter int unsigned W = 8
) (
  input  logic         shift_clk,
  input  logic         rst_n,
  input  logic         ser_in,
  output logic [W-1:0] stages,
  output logic         cascade_out
);
  localparam int unsigned TOP = W - 1;

  logic [W-1:0] nxt;

  always_comb begin
    nxt = {stages[W-2:0], ser_in};
  end

  always_ff @(posedge shift_clk or negedge rst_n) begin
    if (!rst_n) stages <= '0;
    else        stages <= nxt;
  end

  // Retimed cascade tap: opposite edge for hold margin downstream
  always_ff @(negedge shift_clk or negedge rst_n) begin
    if (!rst_n) cascade_out <= 1'b0;
    else        cascade_out <= stages[TOP];
  end
endmodule

// File: rtl/shreg_store_bank.sv
module shreg_store_bank #(
  parameter int unsigned W = 8
) (
  input  logic         latch_clk,
  input  logic         rst_n,
  input  logic [W-1:0] load_d,
  output logic [W-1:0] store_q
);
  always_ff @(posedge latch_clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= load_d;
  end
endmodule

// File: rtl/shreg_out_gate.sv
module shreg_out_gate
  import shreg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] store_q,
  input  logic         out_en_n,
  output logic [W-1:0] sink_en,
  output logic [W-1:0] drive_valid
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] dec;
    always_comb begin
      dec            = pin_gate(store_q[i], out_en_n);
      drive_valid[i] = dec[1];
      sink_en[i]     = dec[0];
    end
  end
endmodule

// File: rtl/shreg_latched_driver.sv
module shreg_latched_driver
  import shreg_pkg::*;
#(
  parameter int unsigned STAGES = STAGES_DEF
) (
  input  logic              shift_clk,
  input  logic              latch_clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              out_en_n,
  output logic [STAGES-1:0] sink_en,
  output logic [STAGES-1:0] drive_valid,
  output logic              cascade_out
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] store_q;

  shreg_shift_chain #(.W(STAGES)) u_chain (
    .shift_clk  (shift_clk),
    .rst_n      (rst_n),
    .ser_in     (ser_in),
    .stages     (shift_q),
    .cascade_out(cascade_out)
  );

  shreg_store_bank #(.W(STAGES)) u_bank (
    .latch_clk(latch_clk),
    .rst_n    (rst_n),
    .load_d   (shift_q),
    .store_q  (store_q)
  );

  shreg_out_gate #(.W(STAGES)) u_gate (
    .store_q    (store_q),
    .out_en_n   (out_en_n),
    .sink_en    (sink_en),
    .drive_valid(drive_valid)
  );
endmodule

// File: rtl/shreg_latched_driver_chk.sv
module shreg_latched_driver_chk #(
  parameter int unsigned W = 8
) (
  input logic         shift_clk,
  input logic         latch_clk,
  input logic         rst_n,
  input logic         ser_in,
  input logic         out_en_n,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] store_q,
  input logic [W-1:0] sink_en,
  input logic [W-1:0] drive_valid,
  input logic         cascade_out
);
  logic         sh_armed, st_armed;
  logic [W-1:0] sh_prev, st_prev;
  logic         sh_prev_in;

  always_ff @(posedge shift_clk or negedge rst_n) begin
    if (!rst_n) sh_armed <= 1'b0;
    else        sh_armed <= 1'b1;
  end

  always_ff @(posedge shift_clk) begin
    sh_prev    <= shift_q;
    sh_prev_in <= ser_in;
  end

  always_ff @(posedge latch_clk or negedge rst_n) begin
    if (!rst_n) st_armed <= 1'b0;
    else        st_armed <= 1'b1;
  end

  always_ff @(posedge latch_clk) begin
    st_prev <= shift_q;
  end

  // R1: one-stage advance per rising shift edge
  p_shift_step_r1: assert property (@(posedge shift_clk) disable iff (!rst_n)
    sh_armed |-> shift_q == {sh_prev[W-2:0], sh_prev_in});

  // R2 / R7: storage holds the stages seen at the previous latch edge
  p_latch_copy_r2: assert property (@(posedge latch_clk) disable iff (!rst_n)
    st_armed |-> store_q == st_prev);

  // R4: cascade tap equals last stage by the next rising edge
  p_cascade_tap_r4: assert property (@(posedge shift_clk) disable iff (!rst_n)
    cascade_out == shift_q[W-1]);

  // R6: disabled outputs are all off
  p_outputs_off_r6: assert property (@(posedge shift_clk) disable iff (!rst_n)
    out_en_n |-> (sink_en == '0 && drive_valid == '0));

  // R3: everything is clear when reset is released
  always @(posedge rst_n) begin
    p_reset_clear_r3: assert (shift_q == '0 && store_q == '0 && cascade_out == 1'b0);
  end
endmodule

bind shreg_latched_driver shreg_latched_driver_chk #(.W(STAGES)) u_chk (
  .shift_clk  (shift_clk),
  .latch_clk  (latch_clk),
  .rst_n      (rst_n),
  .ser_in     (ser_in),
  .out_en_n   (out_en_n),
  .shift_q    (shift_q),
  .store_q    (store_q),
  .sink_en    (sink_en),
  .drive_valid(drive_valid),
  .cascade_out(cascade_out)
);

// File: tb/tb_shreg_latched_driver.sv
`timescale 1ns/1ps
module tb_shreg_latched_driver;
  logic clk = 1'b0;
  logic shift_clk = 1'b0, latch_clk = 1'b0;
  logic rst_n = 1'b0, ser_in = 1'b0, out_en_n = 1'b0;
  logic [7:0] sink_a, sink_b, dv_a, dv_b;
  logic casc_a, casc_b;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shreg_latched_driver #(.STAGES(8)) dut (
    .shift_clk(shift_clk), .latch_clk(latch_clk), .rst_n(rst_n),
    .ser_in(ser_in), .out_en_n(out_en_n),
    .sink_en(sink_a), .drive_valid(dv_a), .cascade_out(casc_a));

  shreg_latched_driver #(.STAGES(8)) dut_b (
    .shift_clk(shift_clk), .latch_clk(latch_clk), .rst_n(rst_n),
    .ser_in(casc_a), .out_en_n(out_en_n),
    .sink_en(sink_b), .drive_valid(dv_b), .cascade_out(casc_b));

  // {word, expected second-device sinks, expected first-device sinks}
  localparam logic [31:0] VEC [4] = '{
    {16'h00FF, 8'h00, 8'hFF},
    {16'h8001, 8'h80, 8'h01},
    {16'h1234, 8'h12, 8'h34},
    {16'hA55A, 8'hA5, 8'h5A}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b; #2;
    shift_clk = 1'b1; #5;
    shift_clk = 1'b0; #3;
  endtask

  task automatic latch_pulse(input logic with_shift, input logic b);
    ser_in = b; #1;
    latch_clk = 1'b1;
    if (with_shift) shift_clk = 1'b1;
    #5;
    latch_clk = 1'b0; shift_clk = 1'b0; #4;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev_a;
    prev_a = 8'h00;
    #20;
    check("R3 reset sinks a", sink_a, 8'h00);
    check("R3 reset sinks b", sink_b, 8'h00);
    check("R5 reset drive_valid", dv_a, 8'hFF);
    check("R3 reset cascade", {6'b0, casc_b, casc_a}, 8'h00);
    rst_n = 1'b1; #5;

    for (int v = 0; v < 4; v++) begin
      logic [15:0] w;
      w = VEC[v][31:16];
      for (int k = 0; k < 16; k++) shift_bit(w[15-k]);
      check("R2 sinks unchanged by shifting", sink_a, prev_a);
      check("R4 cascade of second device", {7'b0, casc_b}, {7'b0, w[15]});
      latch_pulse(1'b0, 1'b0);
      check("R5 first device sinks", sink_a, VEC[v][7:0]);
      check("R8 second device sinks", sink_b, VEC[v][15:8]);
      check("R5 drive_valid all on", dv_a & dv_b, 8'hFF);
      prev_a = VEC[v][7:0];
    end

    // R4: half-cycle retiming (first stage set holds 5A, top bit 0, next 1)
    ser_in = 1'b1; #2;
    shift_clk = 1'b1; #2;
    check("R4 cascade holds in high phase", {7'b0, casc_a}, 8'h00);
    #3; shift_clk = 1'b0; #2;
    check("R4 cascade after falling edge", {7'b0, casc_a}, 8'h01);
    #1;
    // stages now: first B5, second 4A
    latch_pulse(1'b1, 1'b0);
    check("R7 shared edge captures pre-shift a", sink_a, 8'hB5);
    check("R7 shared edge captures pre-shift b", sink_b, 8'h4A);
    latch_pulse(1'b0, 1'b0);
    check("R7 lag closed by lone latch a", sink_a, 8'h6A);
    check("R7 lag closed by lone latch b", sink_b, 8'h95);

    out_en_n = 1'b1; #2;
    check("R6 disabled sinks", sink_a | sink_b, 8'h00);
    check("R6 disabled drive_valid", dv_a | dv_b, 8'h00);
    out_en_n = 1'b0; #2;
    check("R6 storage kept across disable", sink_a, 8'h6A);
    latch_pulse(1'b0, 1'b0);
    check("R6 shift stages kept across disable", sink_b, 8'h95);

    // R3: reset in the middle of a shift sequence
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b1);
    rst_n = 1'b0; #2;
    check("R3 mid-shift reset sinks a", sink_a, 8'h00);
    check("R3 mid-shift reset sinks b", sink_b, 8'h00);
    check("R3 mid-shift reset cascade", {6'b0, casc_b, casc_a}, 8'h00);
    #3; rst_n = 1'b1; #3;
    latch_pulse(1'b0, 1'b0);
    check("R3 shift stages cleared a", sink_a, 8'h00);
    check("R3 shift stages cleared b", sink_b, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule